// File: doc/BRIEF.md
# Multi-Lane Command Intake Queue

This block is the user-side front end of a memory controller port. Every user clock it can take a group of command slots, one per lane. The number of lanes is set by the configured burst length: 4 lanes at burst length 2, 2 at burst length 4 and 1 at burst length 8. Each slot holds a two-bit command code, an address and a bank. A single command-enable pulse qualifies the whole group. The group is accepted whole or not at all. The slots that carry real work go into one shared command ring, and NOP slots are discarded. Each lane also has its own write-data queue. That queue stores a data word and its byte mask, and its width grows with the burst length.

The scheduler drains the command ring through a valid/ready head port and drains each write lane through its own valid/ready port. A two-state controller holds every downstream valid low until the calibration-ready input is seen. States: `ST_WAIT_CAL`, which is entered on reset and keeps accepting but presents nothing, and `ST_SERVE`, which presents queued work. Transitions: `ST_WAIT_CAL` goes to `ST_SERVE` when `cal_done` is high at an edge, and `ST_SERVE` goes to `ST_WAIT_CAL` when `cal_done` is low at an edge.

Top module: `cmd_intake_queue`

## Requirements
- R1: While `usr_rst` is high at an edge, nothing is accepted and both queues are emptied. After reset, `cmd_full`, `wr_full`, `sq_valid` and `wq_valid` are all 0.
- R2: `sq_valid` and every `wq_valid` bit are 0 in the cycle after any edge where `cal_done` was 0. In the cycle after an edge where `cal_done` was 1, each valid output is 1 exactly when its queue holds an entry. Intake continues while `cal_done` is 0.
- R3: When `cmd_full` is 1, a `cmd_en` pulse adds nothing from any lane.
- R4: Lane codes are 2'b00 NOP, 2'b01 write, 2'b10 read and 2'b11 refresh, and any lane may carry any code. NOP slots never enter the ring, so a group made only of NOPs leaves it unchanged.
- R5: Entries leave in the order of acceptance. Within one group, the lower lane index comes first. The head shows the code, address and bank exactly as presented.
- R6: `cmd_full` is 1 exactly when the free ring entries number fewer than the lane count.
- R7: `wr_full[i]` is 1 exactly when lane i's write queue holds `WQ_DEPTH` words. While it is 1, `wr_en[i]` is ignored.
- R8: Each write lane returns its data and mask, kept together as a pair, in push order and independently of the other lanes.
- R9: A pop and a group push at the same edge both take effect. The fill level changes by the number pushed minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| usr_clk | input | 1 | User clock |
| usr_rst | input | 1 | Synchronous reset, active high |
| cal_done | input | 1 | Calibration-ready flag; enables downstream presentation |
| cmd_en | input | 1 | Qualifies the command group this cycle |
| cmd_code | input | 2*LANES | Per-lane command code |
| cmd_addr | input | ADDR_W*LANES | Per-lane address |
| cmd_bank | input | BANK_W*LANES | Per-lane bank |
| cmd_full | output | 1 | Ring cannot take a full group |
| wr_en | input | LANES | Per-lane write-data enable |
| wr_data | input | DW*LANES | Per-lane write data |
| wr_mask | input | MW*LANES | Per-lane byte mask |
| wr_full | output | LANES | Per-lane write queue full |
| sq_valid | output | 1 | Ring head is presented |
| sq_ready | input | 1 | Scheduler pops the ring head |
| sq_code | output | 2 | Head command code |
| sq_addr | output | ADDR_W | Head address |
| sq_bank | output | BANK_W | Head bank |
| wq_valid | output | LANES | Write lane head is presented |
| wq_ready | input | LANES | Scheduler pops a write lane head |
| wq_data | output | DW*LANES | Write lane head data |
| wq_mask | output | MW*LANES | Write lane head mask |

## Verification
A group push and a scheduler pop can land on the same edge of the command ring. In that case the fill level, the full threshold and the head order must all account for both. The random phase keeps `sq_ready` high about three cycles in four while groups of mixed codes keep arriving. A model queue that applies the pop first and then the push predicts `cmd_full` and the head contents. Mismatches in cycles that follow such a double event are reported under R9.

// File: rtl/intake_pkg.sv
package intake_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_WR  = 2'b01,
        CMD_RD  = 2'b10,
        CMD_REF = 2'b11
    } cmd_code_e;

    typedef enum logic {
        ST_WAIT_CAL = 1'b0,
        ST_SERVE    = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/intake_ctl.sv
module intake_ctl
    import intake_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cal_done,
    output logic serve
);

    ctl_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT_CAL: if (cal_done)  state_nx = ST_SERVE;
            ST_SERVE:    if (!cal_done) state_nx = ST_WAIT_CAL;
            default:     state_nx = ST_WAIT_CAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_WAIT_CAL;
        else     state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_SERVE: serve = 1'b1;
            default:  serve = 1'b0;
        endcase
    end

endmodule

// File: rtl/cq_ring.sv
module cq_ring #(
    parameter int LANES = 4,
    parameter int ENT_W = 26,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   push_en,
    input  logic [LANES-1:0]       lane_vld,
    input  logic [LANES*ENT_W-1:0] lane_ent,
    input  logic                   pop,
    output logic [ENT_W-1:0]       head,
    output logic [AW:0]            level,
    output logic                   full
);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [LW-1:0]    slot_off [LANES];
    logic [LW-1:0]    n_push;

    always_comb begin
        logic [LW-1:0] acc;
        acc = '0;
        for (int i = 0; i < LANES; i++) begin
            slot_off[i] = acc;
            if (push_en && lane_vld[i]) acc = acc + LW'(1);
        end
        n_push = acc;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (push_en && lane_vld[i])
                mem[wptr + AW'(slot_off[i])] <= lane_ent[i*ENT_W +: ENT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            wptr  <= wptr + AW'(n_push);
            if (pop) rptr <= rptr + AW'(1);
            level <= level + (AW+1)'(n_push) - (AW+1)'(pop);
        end
    end

    assign head = mem[rptr];
    assign full = level > (AW+1)'(DEPTH - LANES);

endmodule

// File: rtl/wd_lane_fifo.sv
module wd_lane_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + AW'(1);
            if (pop)  rp <= rp + AW'(1);
            cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    assign dout  = mem[rp];
    assign full  = cnt == (AW+1)'(DEPTH);
    assign empty = cnt == '0;

endmodule

// File: rtl/cmd_intake_queue.sv
module cmd_intake_queue
    import intake_pkg::*;
#(
    parameter int BURST_LEN = 2,
    parameter int ADDR_W    = 20,
    parameter int BANK_W    = 4,
    parameter int BASE_DW   = 16,
    parameter int CQ_DEPTH  = 16,
    parameter int WQ_DEPTH  = 8,
    localparam int LANES    = 8 / BURST_LEN,
    localparam int DW       = BASE_DW * BURST_LEN / 2,
    localparam int MW       = DW / 8,
    localparam int ENT_W    = 2 + ADDR_W + BANK_W,
    localparam int CQ_AW    = $clog2(CQ_DEPTH)
) (
    input  logic                    usr_clk,
    input  logic                    usr_rst,
    input  logic                    cal_done,
    input  logic                    cmd_en,
    input  logic [2*LANES-1:0]      cmd_code,
    input  logic [ADDR_W*LANES-1:0] cmd_addr,
    input  logic [BANK_W*LANES-1:0] cmd_bank,
    output logic                    cmd_full,
    input  logic [LANES-1:0]        wr_en,
    input  logic [DW*LANES-1:0]     wr_data,
    input  logic [MW*LANES-1:0]     wr_mask,
    output logic [LANES-1:0]        wr_full,
    output logic                    sq_valid,
    input  logic                    sq_ready,
    output logic [1:0]              sq_code,
    output logic [ADDR_W-1:0]       sq_addr,
    output logic [BANK_W-1:0]       sq_bank,
    output logic [LANES-1:0]        wq_valid,
    input  logic [LANES-1:0]        wq_ready,
    output logic [DW*LANES-1:0]     wq_data,
    output logic [MW*LANES-1:0]     wq_mask
);

    logic                   serve;
    logic                   grp_take;
    logic [LANES-1:0]       lane_vld;
    logic [LANES*ENT_W-1:0] lane_ent;
    logic [ENT_W-1:0]       cq_head;
    logic [CQ_AW:0]         cq_level;

    intake_ctl u_ctl (
        .clk      (usr_clk),
        .rst      (usr_rst),
        .cal_done (cal_done),
        .serve    (serve)
    );

    assign grp_take = cmd_en && !cmd_full && !usr_rst;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic         wd_empty;
        logic [DW+MW-1:0] wd_head;

        assign lane_vld[g] = cmd_code[2*g +: 2] != CMD_NOP;
        assign lane_ent[g*ENT_W +: ENT_W] = {cmd_code[2*g +: 2],
                                             cmd_addr[g*ADDR_W +: ADDR_W],
                                             cmd_bank[g*BANK_W +: BANK_W]};

        wd_lane_fifo #(.W(DW + MW), .DEPTH(WQ_DEPTH)) u_wd (
            .clk   (usr_clk),
            .rst   (usr_rst),
            .push  (wr_en[g] && !wr_full[g] && !usr_rst),
            .din   ({wr_mask[g*MW +: MW], wr_data[g*DW +: DW]}),
            .pop   (wq_valid[g] && wq_ready[g]),
            .dout  (wd_head),
            .full  (wr_full[g]),
            .empty (wd_empty)
        );

        assign wq_valid[g]           = serve && !wd_empty;
        assign wq_data[g*DW +: DW]   = wd_head[DW-1:0];
        assign wq_mask[g*MW +: MW]   = wd_head[DW +: MW];
    end

    cq_ring #(.LANES(LANES), .ENT_W(ENT_W), .DEPTH(CQ_DEPTH)) u_ring (
        .clk      (usr_clk),
        .rst      (usr_rst),
        .push_en  (grp_take),
        .lane_vld (lane_vld),
        .lane_ent (lane_ent),
        .pop      (sq_valid && sq_ready),
        .head     (cq_head),
        .level    (cq_level),
        .full     (cmd_full)
    );

    assign sq_valid = serve && (cq_level != '0);
    assign {sq_code, sq_addr, sq_bank} = cq_head;

endmodule

// File: rtl/intake_checks.sv
module intake_checks #(
    parameter int LANES    = 4,
    parameter int CQ_DEPTH = 16,
    localparam int CQ_AW   = $clog2(CQ_DEPTH)
) (
    input logic               usr_clk,
    input logic               usr_rst,
    input logic               cal_done,
    input logic               cmd_en,
    input logic [2*LANES-1:0] cmd_code,
    input logic               cmd_full,
    input logic               sq_valid,
    input logic               sq_ready,
    input logic [LANES-1:0]   wr_en,
    input logic [LANES-1:0]   wr_full,
    input logic [LANES-1:0]   wq_valid,
    input logic [LANES-1:0]   wq_ready,
    input logic [CQ_AW:0]     cq_level
);

    logic all_nop;
    always_comb begin
        all_nop = 1'b1;
        for (int i = 0; i < LANES; i++)
            if (cmd_code[2*i +: 2] != 2'b00) all_nop = 1'b0;
    end

    AST_RESET_CLEARS: assert property (@(posedge usr_clk)
        usr_rst |=> (cq_level == '0 && !sq_valid)); // R1

    AST_HOLD_UNTIL_CAL: assert property (@(posedge usr_clk) disable iff (usr_rst)
        !cal_done |=> (!sq_valid && wq_valid == '0)); // R2

    AST_FULL_BLOCKS_GROUP: assert property (@(posedge usr_clk) disable iff (usr_rst)
        (cmd_en && cmd_full && !(sq_valid && sq_ready)) |=> $stable(cq_level)); // R3

    AST_NOP_GROUP_DROPPED: assert property (@(posedge usr_clk) disable iff (usr_rst)
        (cmd_en && !cmd_full && all_nop && !(sq_valid && sq_ready)) |=> $stable(cq_level)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge usr_clk) disable iff (usr_rst)
        cq_level <= (CQ_AW+1)'(CQ_DEPTH)); // R6

    for (genvar i = 0; i < LANES; i++) begin : g_wchk
        AST_WR_FULL_HOLDS: assert property (@(posedge usr_clk) disable iff (usr_rst)
            (wr_full[i] && wr_en[i] && !(wq_valid[i] && wq_ready[i])) |=> wr_full[i]); // R7
    end

endmodule

bind cmd_intake_queue intake_checks #(.LANES(LANES), .CQ_DEPTH(CQ_DEPTH)) u_chk (
    .usr_clk  (usr_clk),
    .usr_rst  (usr_rst),
    .cal_done (cal_done),
    .cmd_en   (cmd_en),
    .cmd_code (cmd_code),
    .cmd_full (cmd_full),
    .sq_valid (sq_valid),
    .sq_ready (sq_ready),
    .wr_en    (wr_en),
    .wr_full  (wr_full),
    .wq_valid (wq_valid),
    .wq_ready (wq_ready),
    .cq_level (cq_level)
);

// File: tb/sim_cmd_intake_queue.sv
`timescale 1ns/1ps
module sim_cmd_intake_queue;

    localparam int L = 4, AW = 20, BW = 4, DW = 16, MW = 2, CQD = 16, WQD = 8;

    logic          usr_clk = 1'b0;
    logic          usr_rst = 1'b1;
    logic          cal_done = 1'b0;
    logic          cmd_en = 1'b0;
    logic [2*L-1:0]  cmd_code = '0;
    logic [AW*L-1:0] cmd_addr = '0;
    logic [BW*L-1:0] cmd_bank = '0;
    logic          cmd_full;
    logic [L-1:0]  wr_en = '0;
    logic [DW*L-1:0] wr_data = '0;
    logic [MW*L-1:0] wr_mask = '0;
    logic [L-1:0]  wr_full;
    logic          sq_valid;
    logic          sq_ready = 1'b0;
    logic [1:0]    sq_code;
    logic [AW-1:0] sq_addr;
    logic [BW-1:0] sq_bank;
    logic [L-1:0]  wq_valid;
    logic [L-1:0]  wq_ready = '0;
    logic [DW*L-1:0] wq_data;
    logic [MW*L-1:0] wq_mask;

    always #2 usr_clk = ~usr_clk;

    cmd_intake_queue u0 (.*);

    int total = 0, bad = 0;
    bit done = 1'b0;

    logic [25:0] mq[$];
    logic [17:0] wm_mem [L][WQD];
    int          wm_rd [L];
    int          wm_cnt [L];
    bit          serve_m = 1'b0;
    bit          both_last = 1'b0;

    task automatic chk(bit ok, string tg, logic [63:0] a, logic [63:0] e);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tg, a, e);
        end
    endtask

    function automatic bit exp_full();
        return (CQD - mq.size()) < L;
    endfunction

    task automatic tick();
        bit ev, ef, pop, push, any;
        bit wpop [L];
        bit wpush [L];
        ef = exp_full();
        ev = serve_m && mq.size() > 0;
        chk(cmd_full === ef, both_last ? "R9" : "R6", 64'(cmd_full), 64'(ef));
        chk(sq_valid === ev, "R2", 64'(sq_valid), 64'(ev));
        if (ev) chk({sq_code, sq_addr, sq_bank} === mq[0], both_last ? "R9" : "R5",
                    64'({sq_code, sq_addr, sq_bank}), 64'(mq[0]));
        for (int i = 0; i < L; i++) begin
            bit wf, wv;
            wf = wm_cnt[i] == WQD;
            wv = serve_m && wm_cnt[i] > 0;
            chk(wr_full[i] === wf, "R7", 64'(wr_full[i]), 64'(wf));
            chk(wq_valid[i] === wv, "R2", 64'(wq_valid[i]), 64'(wv));
            if (wv) chk({wq_mask[i*MW +: MW], wq_data[i*DW +: DW]} === wm_mem[i][wm_rd[i]], "R8",
                        64'({wq_mask[i*MW +: MW], wq_data[i*DW +: DW]}), 64'(wm_mem[i][wm_rd[i]]));
            wpop[i]  = wv && wq_ready[i];
            wpush[i] = !usr_rst && wr_en[i] && !wf;
        end
        pop  = ev && sq_ready;
        push = !usr_rst && cmd_en && !ef;
        any  = 1'b0;
        @(posedge usr_clk);
        if (usr_rst) begin
            mq.delete();
            for (int i = 0; i < L; i++) begin wm_rd[i] = 0; wm_cnt[i] = 0; end
        end else begin
            if (pop) void'(mq.pop_front());
            if (push) for (int i = 0; i < L; i++)
                if (cmd_code[2*i +: 2] != 2'b00) begin
                    mq.push_back({cmd_code[2*i +: 2], cmd_addr[i*AW +: AW], cmd_bank[i*BW +: BW]});
                    any = 1'b1;
                end
            for (int i = 0; i < L; i++) begin
                if (wpop[i]) begin wm_rd[i] = (wm_rd[i] + 1) % WQD; wm_cnt[i]--; end
                if (wpush[i]) begin
                    wm_mem[i][(wm_rd[i] + wm_cnt[i]) % WQD] = {wr_mask[i*MW +: MW], wr_data[i*DW +: DW]};
                    wm_cnt[i]++;
                end
            end
        end
        both_last = pop && any;
        serve_m   = !usr_rst && cal_done;
        @(negedge usr_clk);
    endtask

    task automatic rand_cmd(logic [7:0] codes);
        cmd_en   = 1'b1;
        cmd_code = codes;
        cmd_addr = 80'({$urandom, $urandom, $urandom});
        cmd_bank = 16'($urandom);
    endtask

    task automatic rand_wr(logic [3:0] en);
        wr_en   = en;
        wr_data = 64'({$urandom, $urandom});
        wr_mask = 8'($urandom);
    endtask

    task automatic idle();
        cmd_en = 1'b0;
        wr_en  = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        for (int i = 0; i < L; i++) begin wm_rd[i] = 0; wm_cnt[i] = 0; end
        @(negedge usr_clk);
        // R1: traffic during reset is not taken
        rand_cmd(8'h55);
        rand_wr(4'hf);
        repeat (4) tick();
        usr_rst = 1'b0;
        idle();
        chk(cmd_full === 1'b0, "R1", 64'(cmd_full), 0);
        chk(wr_full === '0, "R1", 64'(wr_full), 0);
        chk(sq_valid === 1'b0, "R1", 64'(sq_valid), 0);
        chk(wq_valid === '0, "R1", 64'(wq_valid), 0);
        cal_done = 1'b1;
        repeat (2) tick();
        chk(sq_valid === 1'b0, "R1", 64'(sq_valid), 0);
        chk(wq_valid === '0, "R1", 64'(wq_valid), 0);

        // R6 threshold, then R3 ignored group while full
        cal_done = 1'b0;
        sq_ready = 1'b0;
        repeat (3) begin rand_cmd(8'h55); tick(); end
        chk(cmd_full === 1'b0, "R6", 64'(cmd_full), 0);
        rand_cmd(8'h78);
        tick();
        chk(cmd_full === 1'b1, "R6", 64'(cmd_full), 1);
        rand_cmd(8'hff);
        tick();
        chk(cmd_full === 1'b1, "R3", 64'(cmd_full), 1);
        idle();
        cal_done = 1'b1;
        sq_ready = 1'b1;
        n = 0;
        repeat (20) begin if (sq_valid) n++; tick(); end
        chk(n == 15, "R3", 64'(n), 15);

        // R4: all-NOP group leaves ring empty
        rand_cmd(8'h00);
        tick();
        idle();
        tick();
        chk(sq_valid === 1'b0, "R4", 64'(sq_valid), 0);

        // R7: fill every write lane, then one ignored push
        cal_done = 1'b0;
        wq_ready = '0;
        repeat (8) begin rand_wr(4'hf); tick(); end
        chk(wr_full === 4'hf, "R7", 64'(wr_full), 64'hf);
        rand_wr(4'hf);
        tick();
        idle();
        cal_done = 1'b1;
        wq_ready = 4'hf;
        n = 0;
        repeat (12) begin if (wq_valid[0]) n++; tick(); end
        chk(n == WQD, "R7", 64'(n), 64'(WQD));

        // random phase: R5 R8 R9 with mixed lanes and concurrent pops
        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 2 == 0) rand_cmd(8'($urandom)); else cmd_en = 1'b0;
            rand_wr(4'($urandom));
            sq_ready = ($urandom % 4) != 0;
            wq_ready = 4'($urandom);
            if ($urandom % 64 == 0) cal_done = !cal_done;
            usr_rst = ($urandom % 700 == 0);
            tick();
        end
        usr_rst = 1'b0;
        idle();
        tick();
        finish_run();
    end

endmodule